// File: doc/BRIEF.md
# Latched-Read 40-bit Timestamp Counter

This block keeps a 40-bit time base that only ever counts down. Once software has armed it, it steps by one on every cycle where the tick-enable input is high. It never stops and never raises an interrupt. A 32-bit register bus gives software two words to read. The low word returns counter bits 31:0. The high word returns an 8-bit upper byte together with the arm flag.

Two bus reads cannot sample a 40-bit value at one instant. The block solves this by copying counter bits 39:32 into a shadow byte in the same cycle that it serves a read of the low word. Software reads the low word first and then the high word, keeps the lower 40 bits of the combined value, and always gets a coherent timestamp. Read data is registered and appears one cycle after the request, marked by a valid strobe.

Top module: `ts40_counter`

## Requirements
- R1: After synchronous reset the count is zero, the arm flag is clear, the shadow byte is zero, and bus_rvalid and bus_rdata are zero.
- R2: While the arm flag is clear the count holds its value, whatever the tick input does.
- R3: While armed, each cycle with tick high lowers the count by exactly one, and a cycle with tick low leaves it unchanged.
- R4: The count wraps from zero to all ones (0xFF_FFFF_FFFF) and keeps running.
- R5: A read at address 0x60 returns count bits 31:0 as they stood in the request cycle. The data appears on bus_rdata, with bus_rvalid high, in the following cycle.
- R6: A read at address 0x64 returns the shadow byte in bits 7:0 and the arm flag in bit 8, with every other bit zero. The shadow byte changes only when the low word is read.
- R7: When a low-word read and a tick fall in the same cycle, both the returned low word and the shadow byte come from the count before that decrement.
- R8: A write to address 0x64 sets the arm flag to wdata bit 8 and ignores every other bit. Writes to 0x60 or to any other address change nothing.
- R9: bus_rvalid is high exactly in the cycle after each read request. Reads of unmapped addresses return zero, and bus_rdata is zero whenever bus_rvalid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-step enable, one step per high cycle |
| bus_req | input | 1 | Bus access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |

## Verification
The assertions assume that at most one bus access is presented per cycle and that tick, bus_req, bus_we and bus_addr are settled at every rising edge. They do not assume that tick and reads are kept apart: the same-cycle case is the one the shadow logic exists for. The stimulus drives all inputs on the falling edge and issues a single access per call. It deliberately lines ticks up with low-word reads, including the read that happens at the wrap point.

// File: rtl/ts40_pkg.sv
package ts40_pkg;
  // Classification of the bus access presented in one cycle
  typedef enum logic [2:0] {
    ACC_IDLE    = 3'd0,
    ACC_RD_LO   = 3'd1,
    ACC_RD_HI   = 3'd2,
    ACC_RD_NONE = 3'd3,
    ACC_WR_HI   = 3'd4,
    ACC_WR_NONE = 3'd5
  } acc_e;
endpackage

// File: rtl/ts40_decode.sv
module ts40_decode
  import ts40_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h60,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h64
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output acc_e              acc
);
  always_comb begin
    acc = ACC_IDLE;
    if (req) begin
      if (we) begin
        acc = (addr == HI_ADDR) ? ACC_WR_HI : ACC_WR_NONE;
      end else if (addr == LO_ADDR) begin
        acc = ACC_RD_LO;
      end else if (addr == HI_ADDR) begin
        acc = ACC_RD_HI;
      end else begin
        acc = ACC_RD_NONE;
      end
    end
  end
endmodule

// File: rtl/ts40_down_counter.sv
module ts40_down_counter #(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (run && tick) begin
      cnt <= cnt - ONE;  // wraps from zero to all ones
    end
  end
endmodule

// File: rtl/ts40_ctrl_regs.sv
module ts40_ctrl_regs #(
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            snap,
  input  logic [HI_W-1:0] upper,
  input  logic            arm_wr,
  input  logic            arm_val,
  output logic [HI_W-1:0] shadow,
  output logic            armed
);
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      armed  <= 1'b0;
    end else begin
      if (snap) begin
        shadow <= upper;
      end
      if (arm_wr) begin
        armed <= arm_val;
      end
    end
  end
endmodule

// File: rtl/ts40_counter.sv
module ts40_counter
  import ts40_pkg::*;
#(
  parameter int CNT_W  = 40,
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h60,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h64,
  parameter int ARM_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_rvalid
);
  localparam int HI_W = CNT_W - BUS_W;

  acc_e             acc;
  logic [CNT_W-1:0] cnt_q;
  logic [HI_W-1:0]  shadow_q;
  logic             en_q;
  logic [BUS_W-1:0] hi_word;
  logic [BUS_W-1:0] rdata_d;
  logic             unused_wdata;

  assign unused_wdata = &{1'b0, bus_wdata};

  ts40_decode #(
    .ADDR_W (ADDR_W),
    .LO_ADDR(LO_ADDR),
    .HI_ADDR(HI_ADDR)
  ) u_decode (
    .req (bus_req),
    .we  (bus_we),
    .addr(bus_addr),
    .acc (acc)
  );

  ts40_down_counter #(
    .CNT_W(CNT_W)
  ) u_count (
    .clk (clk),
    .rst (rst),
    .run (en_q),
    .tick(tick),
    .cnt (cnt_q)
  );

  ts40_ctrl_regs #(
    .HI_W(HI_W)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .snap   (acc == ACC_RD_LO),
    .upper  (cnt_q[CNT_W-1:BUS_W]),
    .arm_wr (acc == ACC_WR_HI),
    .arm_val(bus_wdata[ARM_BIT]),
    .shadow (shadow_q),
    .armed  (en_q)
  );

  // High word: shadow byte at the bottom, arm flag at ARM_BIT, rest zero
  always_comb begin
    hi_word = '0;
    hi_word[HI_W-1:0] = shadow_q;
    hi_word[ARM_BIT] = en_q;
  end

  always_comb begin
    unique case (acc)
      ACC_RD_LO: rdata_d = cnt_q[BUS_W-1:0];
      ACC_RD_HI: rdata_d = hi_word;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rdata  <= rdata_d;
      bus_rvalid <= bus_req && !bus_we;
    end
  end
endmodule

// File: rtl/ts40_counter_chk.sv
module ts40_counter_chk #(
  parameter int CNT_W  = 40,
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 8'h60,
  parameter logic [ADDR_W-1:0] HI_ADDR = 8'h64,
  parameter int ARM_BIT = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    tick,
  input logic                    bus_req,
  input logic                    bus_we,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [BUS_W-1:0]        bus_wdata,
  input logic [BUS_W-1:0]        bus_rdata,
  input logic                    bus_rvalid,
  input logic [CNT_W-1:0]        cnt_q,
  input logic [CNT_W-BUS_W-1:0]  shadow_q,
  input logic                    en_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic rd_lo;
  logic rd_any;
  logic wr_hi;
  assign rd_lo  = bus_req && !bus_we && (bus_addr == LO_ADDR);
  assign rd_any = bus_req && !bus_we;
  assign wr_hi  = bus_req && bus_we && (bus_addr == HI_ADDR);

  a_r2_hold_disarmed: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> $stable(cnt_q));

  a_r3_step_on_tick: assert property (@(posedge clk) disable iff (rst)
    (en_q && tick) |=> (cnt_q == $past(cnt_q) - ONE));

  a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    (en_q && !tick) |=> $stable(cnt_q));

  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (en_q && tick && (cnt_q == '0)) |=> (&cnt_q));

  a_r5_low_data: assert property (@(posedge clk) disable iff (rst)
    rd_lo |=> (bus_rdata == $past(cnt_q[BUS_W-1:0])));

  a_r6_shadow_kept: assert property (@(posedge clk) disable iff (rst)
    !rd_lo |=> $stable(shadow_q));

  a_r7_shadow_pre_step: assert property (@(posedge clk) disable iff (rst)
    rd_lo |=> (shadow_q == $past(cnt_q[CNT_W-1:BUS_W])));

  a_r8_arm_write: assert property (@(posedge clk) disable iff (rst)
    wr_hi |=> (en_q == $past(bus_wdata[ARM_BIT])));

  a_r8_arm_kept: assert property (@(posedge clk) disable iff (rst)
    !wr_hi |=> $stable(en_q));

  a_r9_rvalid_on_read: assert property (@(posedge clk) disable iff (rst)
    rd_any |=> bus_rvalid);

  a_r9_no_rvalid: assert property (@(posedge clk) disable iff (rst)
    !rd_any |=> (!bus_rvalid && (bus_rdata == '0)));
endmodule

bind ts40_counter ts40_counter_chk #(
  .CNT_W  (CNT_W),
  .BUS_W  (BUS_W),
  .ADDR_W (ADDR_W),
  .LO_ADDR(LO_ADDR),
  .HI_ADDR(HI_ADDR),
  .ARM_BIT(ARM_BIT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_rvalid(bus_rvalid),
  .cnt_q     (cnt_q),
  .shadow_q  (shadow_q),
  .en_q      (en_q)
);

// File: tb/ts40_counter_bench.sv
module ts40_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] LO = 8'h60;
  localparam logic [7:0] HI = 8'h64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  // Bench-side model of the architectural state
  logic [39:0] m_cnt = '0;
  logic [7:0]  m_sh = '0;
  logic        m_en = 1'b0;

  ts40_counter u_ts40_counter (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_rvalid(bus_rvalid)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One access (or idle) per call; inputs change on the falling edge,
  // response is compared on the next falling edge.
  task automatic op(input string tag, input logic req, input logic we,
                    input logic [7:0] addr, input logic [31:0] wd, input logic tk);
    logic [31:0] exp_d;
    logic        exp_v;
    bus_req = req; bus_we = we; bus_addr = addr; bus_wdata = wd; tick = tk;
    exp_v = req && !we;
    exp_d = '0;
    if (exp_v && addr == LO) exp_d = m_cnt[31:0];
    if (exp_v && addr == HI) exp_d = {23'b0, m_en, m_sh};
    if (exp_v && addr == LO) m_sh = m_cnt[39:32];
    if (m_en && tk) m_cnt = m_cnt - 40'd1;
    if (req && we && addr == HI) m_en = wd[8];
    @(negedge clk);
    check(tag, {bus_rvalid, bus_rdata}, {exp_v, exp_d});
    bus_req = 1'b0; bus_we = 1'b0; tick = 1'b0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state seen at the ports and through reads
    check("R1 idle outputs", {bus_rvalid, bus_rdata}, 33'd0);
    op("R1 low after reset", 1, 0, LO, 0, 0);
    op("R1 high after reset", 1, 0, HI, 0, 0);
    // R2: ticks while disarmed do nothing
    for (int i = 0; i < 5; i++) op("R2 tick disarmed", 0, 0, 0, 0, 1);
    op("R2 low still zero", 1, 0, LO, 0, 0);
    // R8: writes to low word / other bits / unmapped ignored
    op("R8 low write", 1, 1, LO, 32'hFFFF_FFFF, 1);
    op("R8 unmapped write", 1, 1, 8'h68, 32'hFFFF_FFFF, 1);
    op("R8 high after ignored writes", 1, 0, HI, 0, 0);
    op("R8 high write bit8 clear", 1, 1, HI, 32'hFFFF_FEFF, 1);
    op("R8 high still disarmed", 1, 0, HI, 0, 0);
    op("R8 low still zero", 1, 0, LO, 0, 0);
    op("R8 arm", 1, 1, HI, 32'h0000_0100, 0);
    op("R6 high shows arm", 1, 0, HI, 0, 0);
    // R7 + R4: low read coincident with the wrapping tick
    op("R7 low read with tick", 1, 0, LO, 0, 1);
    op("R7 high keeps pre-step byte", 1, 0, HI, 0, 0);
    op("R4 low after wrap", 1, 0, LO, 0, 0);
    op("R4 high after wrap", 1, 0, HI, 0, 0);
    // R9: unmapped read
    op("R9 unmapped read", 1, 0, 8'h40, 0, 0);
    // Sweep: mixed ticks and accesses; R3 R5 R6 R7 R9
    for (int i = 0; i < 600; i++) begin
      logic tk;
      tk = ((i * 7) % 3) != 0;
      if (i == 250)      op("R8 disarm in sweep", 1, 1, HI, 32'h0, tk);
      else if (i == 320) op("R8 rearm in sweep", 1, 1, HI, 32'h100, tk);
      else begin
        case (i % 5)
          0: op("R5 sweep low read", 1, 0, LO, 0, tk);
          1: op("R6 sweep high read", 1, 0, HI, 0, tk);
          3: op("R9 sweep unmapped read", 1, 0, 8'h6C, 0, tk);
          default: op("R3 sweep idle", 0, 0, 0, 0, tk);
        endcase
      end
    end
    op("R3 final low", 1, 0, LO, 0, 0);
    op("R3 final high", 1, 0, HI, 0, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule